// File: doc/BRIEF.md
# Multi-Mode Programmable Interval Timer

This block is one 16-bit down-counting timer channel whose behaviour is chosen by a 3-bit mode code. Software first writes a mode, then a count N. From then on the channel drives one output pin according to the selected waveform. The waveforms are:

- a level that rises at terminal count;
- a retriggerable low pulse;
- a periodic one-clock strobe;
- a square wave;
- a one-clock strobe fired by a software load or by a hardware edge;
- a counter of external events.

A one-cycle interrupt flag marks terminal count in the two counting modes. A latch command copies the running count into a holding register, so software can read it while counting goes on.

The controller has four named states. IDLE holds after a mode write and waits for a count. ARMED waits for a trigger in the triggered modes. RUN counts. DONE follows terminal count.

The transitions are:

- IDLE→RUN on a count load in a free-running mode.
- IDLE/RUN/DONE→ARMED on a count load in a triggered mode.
- ARMED→RUN on a trigger.
- RUN→RUN on a retrigger or a periodic reload.
- RUN→ARMED at the end of a one-shot pulse.
- RUN→DONE at terminal count in the level and strobe modes.
- DONE→ARMED, or DONE→RUN on an immediate retrigger, after a hardware strobe.
- Any state→IDLE on a valid mode write.

The counter clock is the system clock. Gate and event inputs are synchronous to it. Their rising edges are found against a registered copy of the input.

Top module: `pit_timer`

## Requirements
- R1: After reset the mode is 0, `out_pin` is low, `irq` is low and `latch_q` is 0.
- R2: A mode write with code 0..6 makes the code the mode, enters IDLE, discards any count and sets `out_pin` to its idle level. The idle level is low for modes 0 and 6 and high otherwise. Code 7 is ignored. When a mode write and a count load occur in the same cycle, the mode write wins and the load is dropped.
- R3: A loaded count of 0 means 65536.
- R4: Mode 0 (interrupt on terminal count): `out_pin` goes low on the load edge and rises N clocks later. `irq` is high for exactly that one cycle.
- R5: Mode 1 (one-shot): a load arms the channel with the output high. A gate rising edge or `sw_trig` drives the output low for N clocks. A trigger during the pulse restarts the N-clock count.
- R6: Mode 2 (rate generator, N≥2): the output is low for one clock every N clocks, first after N-1 clocks.
- R7: Mode 3 (square wave, N≥2): the output is high for ceil(N/2) clocks and low for floor(N/2) clocks, starting high.
- R8: Mode 4 (software strobe): the output stays high and goes low for one clock N clocks after the load, then stays high.
- R9: Mode 5 (hardware strobe): after a gate rising edge the output goes low for one clock N clocks later. A further rising edge before then restarts the count.
- R10: Mode 6 (event counter): the count drops by one on each rising edge of `evt_in` seen while the gate is high. At the Nth such event, `out_pin` rises and `irq` pulses for one cycle.
- R11: `latch_cmd` high in a cycle loads `latch_q` with the count held in that cycle (65536 reads as 0). Otherwise `latch_q` holds its value. Counting is not disturbed.
- R12: In modes 0, 2, 3, 4 and 6, a low gate freezes the count and the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode write strobe |
| mode_val | input | 3 | Mode code 0..6 |
| load_we | input | 1 | Count load strobe |
| load_val | input | 16 | Count N, 0 meaning 65536 |
| sw_trig | input | 1 | Software trigger for the one-shot mode |
| latch_cmd | input | 1 | Capture the running count |
| gate_in | input | 1 | Gate level or hardware trigger |
| evt_in | input | 1 | External event input |
| out_pin | output | 1 | Timer output |
| irq | output | 1 | Terminal-count interrupt pulse |
| latch_q | output | 16 | Captured count |

## Verification
Each strobe, load, trigger or event takes effect at the next clock edge. `out_pin` and `irq` change at that same edge. `latch_q` shows the count from the cycle in which `latch_cmd` was high, one edge later. Waveform timing is then counted in whole clocks from that first edge.

The bench drives inputs on the falling edge and advances its reference model on the rising edge. It compares all outputs at every falling edge. Directed checks measure each low and high interval in clock counts, and compare them with N, ceil(N/2), floor(N/2) or 1 as the requirement states.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [2:0] {
        M_TCINT   = 3'd0,
        M_ONESHOT = 3'd1,
        M_RATE    = 3'd2,
        M_SQUARE  = 3'd3,
        M_SWSTB   = 3'd4,
        M_HWSTB   = 3'd5,
        M_EVENT   = 3'd6
    } pit_mode_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARMED = 2'd1,
        S_RUN   = 2'd2,
        S_DONE  = 2'd3
    } pit_state_e;

    localparam logic [2:0] MODE_RESERVED = 3'd7;

    function automatic logic idle_level(input pit_mode_e m);
        return !(m == M_TCINT || m == M_EVENT);
    endfunction

endpackage

// File: rtl/pit_edge.sv
module pit_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sig_in,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] sig_d;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sig_d[i] <= 1'b0;
            else        sig_d[i] <= sig_in[i];
        end
        assign rise[i] = sig_in[i] & ~sig_d[i];
    end

endmodule

// File: rtl/pit_latch.sv
module pit_latch #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch_cmd,
    input  logic [CNT_W-1:0] cnt_view,
    output logic [CNT_W-1:0] latch_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         latch_q <= '0;
        else if (latch_cmd) latch_q <= cnt_view;
    end

    a_r11_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_cmd |=> $stable(latch_q));

endmodule

// File: rtl/pit_core.sv
module pit_core
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic [2:0]       mode_val,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    input  logic             sw_trig,
    input  logic             gate_lvl,
    input  logic             gate_rise,
    input  logic             evt_rise,
    output logic             out_q,
    output logic             irq_q,
    output logic [CNT_W-1:0] cnt_view
);
    localparam int FULL_W = CNT_W + 1;
    localparam logic [FULL_W-1:0] ONE = FULL_W'(1);
    localparam logic [FULL_W-1:0] TWO = FULL_W'(2);

    pit_state_e        state, st_d;
    pit_mode_e         mode, mode_d;
    logic [FULL_W-1:0] cnt, cnt_d, reload, rel_d, load_full;
    logic              out_d, irq_d, tick, trig;

    function automatic logic [FULL_W-1:0] hi_len(input logic [FULL_W-1:0] x);
        return (x >> 1) + {{(FULL_W-1){1'b0}}, x[0]};
    endfunction

    function automatic logic [FULL_W-1:0] lo_len(input logic [FULL_W-1:0] x);
        return ((x >> 1) == '0) ? ONE : (x >> 1);
    endfunction

    assign load_full = {(load_val == '0), load_val};
    assign cnt_view  = cnt[CNT_W-1:0];

    always_comb begin
        unique case (mode)
            M_EVENT:           tick = evt_rise & gate_lvl;
            M_ONESHOT, M_HWSTB: tick = 1'b1;
            default:           tick = gate_lvl;
        endcase
        trig = (mode == M_ONESHOT) ? (gate_rise | sw_trig) : gate_rise;
    end

    always_comb begin
        st_d   = state;
        mode_d = mode;
        cnt_d  = cnt;
        rel_d  = reload;
        out_d  = out_q;
        irq_d  = 1'b0;
        if (mode_we && mode_val != MODE_RESERVED) begin
            mode_d = pit_mode_e'(mode_val);
            st_d   = S_IDLE;
            cnt_d  = '0;
            out_d  = idle_level(pit_mode_e'(mode_val));
        end else if (load_we) begin
            rel_d = load_full;
            unique case (mode)
                M_ONESHOT, M_HWSTB: begin
                    st_d = S_ARMED; cnt_d = '0; out_d = 1'b1;
                end
                M_SQUARE: begin
                    st_d = S_RUN; cnt_d = hi_len(load_full); out_d = 1'b1;
                end
                M_TCINT, M_EVENT: begin
                    st_d = S_RUN; cnt_d = load_full; out_d = 1'b0;
                end
                default: begin
                    st_d = S_RUN; cnt_d = load_full; out_d = 1'b1;
                end
            endcase
        end else begin
            unique case (state)
                S_IDLE: st_d = S_IDLE;
                S_ARMED: begin
                    if (trig) begin
                        cnt_d = reload;
                        st_d  = S_RUN;
                        out_d = (mode != M_ONESHOT);
                    end
                end
                S_RUN: begin
                    if ((mode == M_ONESHOT || mode == M_HWSTB) && trig) begin
                        cnt_d = reload;
                    end else if (tick) begin
                        unique case (mode)
                            M_TCINT, M_EVENT: begin
                                if (cnt == ONE) begin
                                    cnt_d = '0; out_d = 1'b1; irq_d = 1'b1; st_d = S_DONE;
                                end else cnt_d = cnt - ONE;
                            end
                            M_ONESHOT: begin
                                if (cnt == ONE) begin
                                    cnt_d = '0; out_d = 1'b1; st_d = S_ARMED;
                                end else cnt_d = cnt - ONE;
                            end
                            M_RATE: begin
                                if (cnt == ONE) begin
                                    cnt_d = reload; out_d = 1'b1;
                                end else begin
                                    cnt_d = cnt - ONE; out_d = !(cnt == TWO);
                                end
                            end
                            M_SQUARE: begin
                                if (cnt == ONE) begin
                                    out_d = ~out_q;
                                    cnt_d = out_q ? lo_len(reload) : hi_len(reload);
                                end else cnt_d = cnt - ONE;
                            end
                            default: begin
                                if (cnt == ONE) begin
                                    cnt_d = '0; out_d = 1'b0; st_d = S_DONE;
                                end else cnt_d = cnt - ONE;
                            end
                        endcase
                    end
                end
                S_DONE: begin
                    if (mode == M_SWSTB) begin
                        out_d = 1'b1;
                    end else if (mode == M_HWSTB) begin
                        out_d = 1'b1;
                        if (trig) begin
                            cnt_d = reload; st_d = S_RUN;
                        end else st_d = S_ARMED;
                    end
                end
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            mode   <= M_TCINT;
            cnt    <= '0;
            reload <= '0;
        end else begin
            state  <= st_d;
            mode   <= mode_d;
            cnt    <= cnt_d;
            reload <= rel_d;
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            out_q <= out_d;
            irq_q <= irq_d;
        end
    end

    a_r4_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);

    a_r10_irq_modes: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (mode == M_TCINT || mode == M_EVENT));

    a_r2_mode_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && mode_val != MODE_RESERVED) |=> (state == S_IDLE));

    a_r3_run_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN) |-> (cnt != '0 && cnt <= (ONE << CNT_W)));

    a_r6_rate_single_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_RATE && state == S_RUN && !out_q && gate_lvl && !mode_we && !load_we)
        |=> out_q);

    a_r12_gate_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && !gate_lvl && !mode_we && !load_we &&
         mode != M_ONESHOT && mode != M_HWSTB) |=> ($stable(cnt) && $stable(out_q)));

endmodule

// File: rtl/pit_timer.sv
module pit_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic [2:0]       mode_val,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    input  logic             sw_trig,
    input  logic             latch_cmd,
    input  logic             gate_in,
    input  logic             evt_in,
    output logic             out_pin,
    output logic             irq,
    output logic [CNT_W-1:0] latch_q
);
    logic [1:0]       rises;
    logic [CNT_W-1:0] cnt_view;

    pit_edge #(.WIDTH(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in ({evt_in, gate_in}),
        .rise   (rises)
    );

    pit_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_we   (mode_we),
        .mode_val  (mode_val),
        .load_we   (load_we),
        .load_val  (load_val),
        .sw_trig   (sw_trig),
        .gate_lvl  (gate_in),
        .gate_rise (rises[0]),
        .evt_rise  (rises[1]),
        .out_q     (out_pin),
        .irq_q     (irq),
        .cnt_view  (cnt_view)
    );

    pit_latch #(.CNT_W(CNT_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_cmd (latch_cmd),
        .cnt_view  (cnt_view),
        .latch_q   (latch_q)
    );

endmodule

// File: tb/pit_timer_bench.sv
module pit_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_we = 1'b0, load_we = 1'b0, sw_trig = 1'b0, latch_cmd = 1'b0;
    logic        gate_in = 1'b0, evt_in = 1'b0;
    logic [2:0]  mode_val = 3'd0;
    logic [15:0] load_val = 16'd0;
    logic        out_pin, irq;
    logic [15:0] latch_q;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    // behavioural reference model state
    int r_mode = 0, r_st = 0, r_cnt = 0, r_n = 0, r_out = 0, r_irq = 0, r_latch = 0;
    int r_gp = 0, r_ep = 0;

    always #2 clk = ~clk;

    pit_timer u_pit_timer (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_val(mode_val),
        .load_we(load_we), .load_val(load_val), .sw_trig(sw_trig),
        .latch_cmd(latch_cmd), .gate_in(gate_in), .evt_in(evt_in),
        .out_pin(out_pin), .irq(irq), .latch_q(latch_q)
    );

    function automatic string mtag(int m);
        case (m)
            0: return "R4"; 1: return "R5"; 2: return "R6"; 3: return "R7";
            4: return "R8"; 5: return "R9"; default: return "R10";
        endcase
    endfunction

    function automatic int half_up(int n);   return (n + 1) / 2; endfunction
    function automatic int half_dn(int n);   return (n / 2 == 0) ? 1 : n / 2; endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            r_mode = 0; r_st = 0; r_cnt = 0; r_n = 0; r_out = 0; r_irq = 0;
            r_latch = 0; r_gp = 0; r_ep = 0;
        end else begin
            int gr, er, tk, tg;
            gr = (gate_in && !r_gp) ? 1 : 0;
            er = (evt_in && !r_ep) ? 1 : 0;
            r_gp = gate_in; r_ep = evt_in;
            if (latch_cmd) r_latch = r_cnt % 65536;
            r_irq = 0;
            tk = (r_mode == 6) ? (er && gate_in) : ((r_mode == 1 || r_mode == 5) ? 1 : gate_in);
            tg = (r_mode == 1) ? (gr || sw_trig) : gr;
            if (mode_we && mode_val != 3'd7) begin
                r_mode = mode_val; r_st = 0; r_cnt = 0;
                r_out = (r_mode == 0 || r_mode == 6) ? 0 : 1;
            end else if (load_we) begin
                r_n = (load_val == 0) ? 65536 : load_val;
                if (r_mode == 1 || r_mode == 5) begin r_st = 1; r_cnt = 0; r_out = 1; end
                else begin
                    r_st = 2;
                    r_cnt = (r_mode == 3) ? half_up(r_n) : r_n;
                    r_out = (r_mode == 0 || r_mode == 6) ? 0 : 1;
                end
            end else if (r_st == 1) begin
                if (tg) begin r_cnt = r_n; r_st = 2; r_out = (r_mode == 1) ? 0 : 1; end
            end else if (r_st == 2) begin
                if ((r_mode == 1 || r_mode == 5) && tg) r_cnt = r_n;
                else if (tk) begin
                    if (r_mode == 2) begin
                        if (r_cnt == 1) begin r_cnt = r_n; r_out = 1; end
                        else begin r_cnt--; r_out = (r_cnt == 1) ? 0 : 1; end
                    end else if (r_mode == 3) begin
                        if (r_cnt == 1) begin
                            r_cnt = r_out ? half_dn(r_n) : half_up(r_n);
                            r_out = !r_out;
                        end else r_cnt--;
                    end else if (r_cnt > 1) r_cnt--;
                    else begin
                        r_cnt = 0;
                        if (r_mode == 0 || r_mode == 6) begin r_out = 1; r_irq = 1; r_st = 3; end
                        else if (r_mode == 1) begin r_out = 1; r_st = 1; end
                        else begin r_out = 0; r_st = 3; end
                    end
                end
            end else if (r_st == 3) begin
                if (r_mode == 4) r_out = 1;
                else if (r_mode == 5) begin
                    r_out = 1;
                    if (tg) begin r_cnt = r_n; r_st = 2; end else r_st = 1;
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // per-cycle comparison and watchdog
    always @(negedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog: actual cycles=%0d expected below 190000", cyc);
            finish_run();
        end
        if (rst_n) begin
            checks += 3;
            if (out_pin !== r_out[0]) begin
                fails++;
                $display("FAIL %s out_pin cycle %0d: actual=%0b expected=%0d", mtag(r_mode), cyc, out_pin, r_out);
            end
            if (irq !== r_irq[0]) begin
                fails++;
                $display("FAIL %s irq cycle %0d: actual=%0b expected=%0d", mtag(r_mode), cyc, irq, r_irq);
            end
            if (latch_q !== r_latch[15:0]) begin
                fails++;
                $display("FAIL R11 latch_q cycle %0d: actual=%0d expected=%0d", cyc, latch_q, r_latch);
            end
        end
    end

    task automatic chk(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_mode(int m);
        mode_val = 3'(m); mode_we = 1'b1; @(negedge clk); mode_we = 1'b0;
    endtask
    task automatic set_count(int n);
        load_val = 16'(n); load_we = 1'b1; @(negedge clk); load_we = 1'b0;
    endtask
    task automatic wait_level(logic lvl, output int n);
        n = 0;
        while (out_pin !== lvl && n < 200000) begin @(negedge clk); n++; end
    endtask
    task automatic event_pulse();
        evt_in = 1'b1; @(negedge clk); evt_in = 1'b0; @(negedge clk);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(out_pin, 0, "R1 reset out_pin");
        chk(irq, 0, "R1 reset irq");
        chk(latch_q, 0, "R1 reset latch_q");

        // R4 interrupt on terminal count
        set_mode(0); gate_in = 1'b1;
        set_count(5);
        wait_level(1'b1, n); chk(n, 5, "R4 clocks to terminal count");
        chk(irq, 1, "R4 irq at terminal count");
        @(negedge clk); chk(irq, 0, "R4 irq single cycle");

        // R12 gate low freezes count
        set_count(6);
        repeat (2) @(negedge clk);
        gate_in = 1'b0; repeat (3) @(negedge clk);
        chk(out_pin, 0, "R12 out held while gate low");
        gate_in = 1'b1;
        wait_level(1'b1, n); chk(n, 4, "R12 remaining count after pause");

        // R6 rate generator
        set_mode(2); set_count(4);
        wait_level(1'b0, n); chk(n, 3, "R6 first low after N-1");
        wait_level(1'b1, n); chk(n, 1, "R6 low width");
        wait_level(1'b0, n); chk(n, 3, "R6 high width N-1");

        // R7 square wave, odd then even N
        set_mode(3); set_count(5);
        wait_level(1'b0, n); chk(n, 3, "R7 odd high phase");
        wait_level(1'b1, n); chk(n, 2, "R7 odd low phase");
        wait_level(1'b0, n); chk(n, 3, "R7 odd high phase again");
        set_count(6);
        wait_level(1'b0, n); chk(n, 3, "R7 even high phase");
        wait_level(1'b1, n); chk(n, 3, "R7 even low phase");

        // R8 software strobe
        set_mode(4); set_count(3);
        wait_level(1'b0, n); chk(n, 3, "R8 strobe delay");
        wait_level(1'b1, n); chk(n, 1, "R8 strobe width");
        repeat (6) @(negedge clk); chk(out_pin, 1, "R8 stays high after strobe");

        // R2 mode write discards count; reserved code ignored
        set_mode(2); set_count(10); repeat (3) @(negedge clk);
        set_mode(3); chk(out_pin, 1, "R2 idle level high");
        n = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (!out_pin) n++; end
        chk(n, 0, "R2 no counting after mode write");
        set_mode(0); chk(out_pin, 0, "R2 idle level low");
        set_mode(4); set_count(3); set_mode(7);
        wait_level(1'b0, n); chk(n, 2, "R2 reserved mode ignored");
        mode_val = 3'd2; load_val = 16'd5; mode_we = 1'b1; load_we = 1'b1;
        @(negedge clk); mode_we = 1'b0; load_we = 1'b0;
        repeat (8) @(negedge clk); chk(out_pin, 1, "R2 load dropped with mode write");

        // R5 one-shot with retrigger and software trigger
        set_mode(1); gate_in = 1'b0; set_count(4);
        chk(out_pin, 1, "R5 armed high");
        gate_in = 1'b1; @(negedge clk); chk(out_pin, 0, "R5 low on trigger");
        gate_in = 1'b0; @(negedge clk); gate_in = 1'b1; @(negedge clk);
        wait_level(1'b1, n); chk(n, 4, "R5 retrigger restarts");
        sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
        wait_level(1'b1, n); chk(n, 4, "R5 software trigger width");

        // R9 hardware strobe with retrigger
        set_mode(5); gate_in = 1'b0; set_count(3);
        gate_in = 1'b1; @(negedge clk);
        wait_level(1'b0, n); chk(n, 3, "R9 strobe delay");
        wait_level(1'b1, n); chk(n, 1, "R9 strobe width");
        gate_in = 1'b0; @(negedge clk); gate_in = 1'b1; @(negedge clk);
        gate_in = 1'b0; @(negedge clk); gate_in = 1'b1; @(negedge clk);
        wait_level(1'b0, n); chk(n, 3, "R9 retrigger restarts");

        // R10 event counter, gate low masks events
        set_mode(6); gate_in = 1'b1; set_count(3);
        event_pulse();
        gate_in = 1'b0; event_pulse(); gate_in = 1'b1;
        event_pulse(); chk(out_pin, 0, "R10 two counted events");
        evt_in = 1'b1; @(negedge clk);
        chk(out_pin, 1, "R10 output at third event");
        chk(irq, 1, "R10 irq at third event");
        evt_in = 1'b0; @(negedge clk);

        // R11 on-the-fly latch
        set_mode(2); set_count(1000);
        repeat (10) @(negedge clk);
        latch_cmd = 1'b1; @(negedge clk); latch_cmd = 1'b0;
        chk(latch_q, 990, "R11 latched count");
        repeat (5) @(negedge clk); chk(latch_q, 990, "R11 latch holds");

        // R3 count of 0 means 65536
        set_mode(4); set_count(0);
        wait_level(1'b0, n); chk(n, 65536, "R3 full-range count");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule